// File: doc/BRIEF.md
# LED Driver Open/Short Fault-Scan Sequencer

This block runs on the host side of a chain of 16-channel serial constant-current LED sink drivers and carries out one complete open/short fault scan each time it is started. It produces the four wires the chain already uses for display data: a shift clock, serial data, a level latch and an active-low output enable. It reads the chain's serial return line and collects the result in a fault vector.

A scan is a fixed series of driver-clock slots. Five slots carry the key pattern that puts the drivers into their detect mode. Sixteen slots per device shift in ones, so that every output is on while it is sensed. One slot with no clock holds the latch high. Enable is then held low for a window of at least 1 µs, again with no clock. Sixteen clocked slots per device read the results back, and five final slots carry the key pattern that returns the drivers to normal mode. One slot is one driver-clock period. Its length comes from the system clock frequency. It is long enough to meet the driver's maximum clock rate and its minimum enable pulse width.

A one-cycle done pulse ends the scan. Each result bit then sits at the position of its channel, and a zero marks a faulty channel.

Top module: `led_scan_seq`

## Requirements
- R1: After reset, and whenever no scan runs: enable is high, and the driver clock, latch, data, busy and done outputs are low. The fault vector resets to all ones.
- R2: A scan begins with five clocked slots. At their rising clock edges, enable is high, low, high, high, high and latch is low, low, low, high, low.
- R3: The next 16×N_DEV rising edges carry data 1, with latch low and enable high.
- R4: Next comes one slot in which latch is high for one full driver-clock period (2×HALF system cycles) with no clock edge. This is the second latch-high run of the scan.
- R5: Enable then stays low for the sense window, with latch low and no clock edge. The window is SENSE_SL slots, the smallest whole number of slots covering SENSE_NS. With the defaults this is 5 slots, or 100 system cycles.
- R6: With enable high, 16×N_DEV clocked readback slots follow. The return line is sampled just before each rising edge, and the i-th sample (counting from 0) is stored in fault bit 16×N_DEV−1−i. The farthest device's channel 15 therefore lands in the top bit, and device k of the chain (0 nearest the host) occupies bits 16k+15 down to 16k.
- R7: A scan ends with five clocked slots in which enable is high, low, high, high, high and latch stays low.
- R8: Data, latch and enable change only while the driver clock is low, at its falling edge. Each clock high phase lasts exactly HALF system cycles, where HALF = max(ceil(SYS_HZ/(2·DRV_HZ)), ceil(EN_MIN_NS·SYS_HZ/2e9)). With the defaults HALF is 10 and a scan has 10+32×N_DEV rising edges.
- R9: Busy rises in the cycle after start is sampled and stays high through the single cycle in which done is high. In the cycle after done, both busy and done are low.
- R10: A start request during a scan has no effect: the scan keeps the same edge count and fault result, and gives exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Scan request, sampled when idle |
| ret_i | input | 1 | Serial return line from the last device of the chain |
| drv_clk_o | output | 1 | Driver shift clock |
| drv_data_o | output | 1 | Serial data to the first device |
| drv_latch_o | output | 1 | Level latch to the drivers |
| drv_oen_o | output | 1 | Active-low output enable to the drivers |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| faults_o | output | 16×N_DEV | Scan result, 0 marks a faulty channel |

## Verification
The bench models the chain's return line, which shifts a chosen pattern out through the readback slots, and sends the scan several patterns:
- All ones and all zeros show that no constant value is forced.
- A single zero at the lowest bit, and another at the highest bit, pin down the bit order, so a reversed or off-by-one mapping is caught.
- Alternating bits and seeded random vectors test the mapping across the whole width.

Every scan also records the enable, latch and data levels at each rising edge, the length of each latch and enable-low run, and the clock high widths. One scan receives extra start pulses partway through. Another holds start high for several cycles. These two show that a second request neither restarts nor doubles the scan.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ENTER, ST_LOAD, ST_LATCH, ST_SENSE, ST_READ, ST_EXIT, ST_FIN
  } scan_st_e;

  typedef struct packed {
    logic data;
    logic latch;
    logic oen;
    logic pulse;
  } slot_drv_t;

  localparam int KEY_SLOTS = 5;

  // System cycles per driver-clock half period: meets both the maximum
  // driver clock rate and the minimum enable pulse (one full slot).
  function automatic int unsigned half_cycles(longint sys_hz, longint drv_hz, longint en_ns);
    longint by_freq;
    longint by_en;
    by_freq = (sys_hz + 2 * drv_hz - 1) / (2 * drv_hz);
    by_en   = (en_ns * sys_hz + 64'd1_999_999_999) / 64'd2_000_000_000;
    if (by_en > by_freq) by_freq = by_en;
    if (by_freq < 1) by_freq = 1;
    return int'(by_freq);
  endfunction

  // Whole slots needed to cover the sense window.
  function automatic int unsigned sense_slots(longint sys_hz, longint win_ns, longint half);
    longint cyc;
    longint sl;
    cyc = (win_ns * sys_hz + 64'd999_999_999) / 64'd1_000_000_000;
    sl  = (cyc + 2 * half - 1) / (2 * half);
    if (sl < 1) sl = 1;
    return int'(sl);
  endfunction

  // Enable level in slot k of either key sequence (low only in slot 1).
  function automatic logic key_oen(int k);
    return (k != 1);
  endfunction

  // Latch level in slot k: high only in slot 3 of the entry sequence.
  function automatic logic key_latch(int k, logic entry);
    return entry && (k == 3);
  endfunction

endpackage

// File: rtl/scan_clkgen.sv
module scan_clkgen #(
  parameter int HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic rise_o,
  output logic slot_end_o
);
  localparam int CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt;
  logic          ph;
  logic          half_end;

  assign half_end   = run_i && (cnt == CW'(HALF - 1));
  assign rise_o     = half_end && !ph;
  assign slot_end_o = half_end && ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (!run_i) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (half_end) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8: a rising event is always followed by a slot end, never by another rise
  a_r8_rise_then_end: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/scan_pattern.sv
module scan_pattern
  import led_scan_pkg::*;
#(
  parameter int IW = 6
) (
  input  scan_st_e       st_i,
  input  logic [IW-1:0]  idx_i,
  output slot_drv_t      drv_o
);
  always_comb begin
    drv_o = '{data: 1'b0, latch: 1'b0, oen: 1'b1, pulse: 1'b0};
    unique case (st_i)
      ST_ENTER: begin
        drv_o.oen   = key_oen(int'(idx_i));
        drv_o.latch = key_latch(int'(idx_i), 1'b1);
        drv_o.pulse = 1'b1;
      end
      ST_LOAD: begin
        drv_o.data  = 1'b1;
        drv_o.pulse = 1'b1;
      end
      ST_LATCH: drv_o.latch = 1'b1;
      ST_SENSE: drv_o.oen   = 1'b0;
      ST_READ:  drv_o.pulse = 1'b1;
      ST_EXIT: begin
        drv_o.oen   = key_oen(int'(idx_i));
        drv_o.latch = key_latch(int'(idx_i), 1'b0);
        drv_o.pulse = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/scan_capture.sv
module scan_capture #(
  parameter int NB = 32,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [IW-1:0] idx_i,
  input  logic          bit_i,
  output logic [NB-1:0] vec_o
);
  for (genvar g = 0; g < NB; g++) begin : g_bit
    logic hit;
    assign hit = take_i && (idx_i == IW'(NB - 1 - g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vec_o[g] <= 1'b1;
      else if (hit) vec_o[g] <= bit_i;
    end
  end

  // R6: one sample lands in exactly one bit
  a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> ($countones(vec_o ^ $past(vec_o)) <= 1));
endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq
  import led_scan_pkg::*;
#(
  parameter int N_DEV     = 2,
  parameter int SYS_HZ    = 100_000_000,
  parameter int DRV_HZ    = 5_000_000,
  parameter int EN_MIN_NS = 200,
  parameter int SENSE_NS  = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                ret_i,
  output logic                drv_clk_o,
  output logic                drv_data_o,
  output logic                drv_latch_o,
  output logic                drv_oen_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [16*N_DEV-1:0] faults_o
);
  localparam int NB       = 16 * N_DEV;
  localparam int HALF     = int'(half_cycles(longint'(SYS_HZ), longint'(DRV_HZ), longint'(EN_MIN_NS)));
  localparam int SENSE_SL = int'(sense_slots(longint'(SYS_HZ), longint'(SENSE_NS), longint'(HALF)));
  localparam int MAXI     = (NB > SENSE_SL) ? NB : SENSE_SL;
  localparam int IW       = $clog2(MAXI + 1);

  scan_st_e      st_q, st_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          run;
  logic          rise_ev;
  logic          slot_end;
  logic          take;
  logic          pulse_q;
  logic          idx_last;
  slot_drv_t     drv_n;

  // Events brought out for the assertions
  assign run  = (st_q != ST_IDLE) && (st_q != ST_FIN);
  assign take = rise_ev && (st_q == ST_READ);

  scan_clkgen #(.HALF(HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .rise_o(rise_ev), .slot_end_o(slot_end)
  );

  function automatic logic [IW-1:0] last_idx(scan_st_e s);
    case (s)
      ST_ENTER, ST_EXIT: return IW'(KEY_SLOTS - 1);
      ST_LOAD, ST_READ:  return IW'(NB - 1);
      ST_SENSE:          return IW'(SENSE_SL - 1);
      default:           return '0;
    endcase
  endfunction

  assign idx_last = (idx_q == last_idx(st_q));

  always_comb begin
    st_n  = st_q;
    idx_n = idx_q;
    if (st_q == ST_IDLE) begin
      if (start_i) begin
        st_n  = ST_ENTER;
        idx_n = '0;
      end
    end else if (st_q == ST_FIN) begin
      st_n = ST_IDLE;
    end else if (slot_end) begin
      if (idx_last) begin
        idx_n = '0;
        unique case (st_q)
          ST_ENTER: st_n = ST_LOAD;
          ST_LOAD:  st_n = ST_LATCH;
          ST_LATCH: st_n = ST_SENSE;
          ST_SENSE: st_n = ST_READ;
          ST_READ:  st_n = ST_EXIT;
          default:  st_n = ST_FIN;
        endcase
      end else begin
        idx_n = idx_q + 1'b1;
      end
    end
  end

  scan_pattern #(.IW(IW)) u_pat (.st_i(st_n), .idx_i(idx_n), .drv_o(drv_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      drv_data_o  <= 1'b0;
      drv_latch_o <= 1'b0;
      drv_oen_o   <= 1'b1;
      pulse_q     <= 1'b0;
      drv_clk_o   <= 1'b0;
    end else begin
      st_q        <= st_n;
      idx_q       <= idx_n;
      drv_data_o  <= drv_n.data;
      drv_latch_o <= drv_n.latch;
      drv_oen_o   <= drv_n.oen;
      pulse_q     <= drv_n.pulse;
      if (slot_end)                drv_clk_o <= 1'b0;
      else if (rise_ev && pulse_q) drv_clk_o <= 1'b1;
    end
  end

  scan_capture #(.NB(NB), .IW(IW)) u_cap (
    .clk(clk), .rst_n(rst_n), .take_i(take), .idx_i(idx_q),
    .bit_i(ret_i), .vec_o(faults_o)
  );

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_FIN);

  // R1: idle drivers see enable high, no clock, no latch
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (drv_oen_o && !drv_clk_o && !drv_latch_o));
  // R8: wires hold still while the driver clock is high
  a_r8_quiet_high: assert property (@(posedge clk) disable iff (!rst_n)
    drv_clk_o |-> ($stable(drv_data_o) && $stable(drv_latch_o) && $stable(drv_oen_o)));
  // R5: latch never high while outputs are enabled
  a_r5_no_latch_lit: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_oen_o |-> !drv_latch_o);
  // R5: no clock edges during the sense window
  a_r5_dark_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SENSE) |-> !drv_clk_o);
  // R6: return sampled with enable high, clock still low
  a_r6_sample_low: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (drv_oen_o && !drv_clk_o));
  // R9: done lasts one cycle and busy drops after it
  a_r9_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  // R10: busy cannot drop before done
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/sim_led_scan_seq.sv
module sim_led_scan_seq;
  localparam int N_DEV = 2;
  localparam int NB    = 16 * N_DEV;
  localparam int HALF  = 10;           // max(ceil(100e6/10e6), ceil(200*100e6/2e9))
  localparam int SENSE_CYC = 100;      // 5 slots of 20 cycles cover 1 us
  localparam int RB0   = 5 + NB;       // first readback rise
  localparam int NRISE = 10 + 2 * NB;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic ret;
  logic drv_clk, drv_data, drv_latch, drv_oen, busy, done;
  logic [NB-1:0] faults;

  led_scan_seq #(.N_DEV(N_DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ret_i(ret),
    .drv_clk_o(drv_clk), .drv_data_o(drv_data), .drv_latch_o(drv_latch),
    .drv_oen_o(drv_oen), .busy_o(busy), .done_o(done), .faults_o(faults)
  );

  always #5 clk = ~clk;

  int errs = 0, checks = 0;
  logic [NB-1:0] pat = '0;
  int rc;
  logic oen_r[0:127], lat_r[0:127], dat_r[0:127];
  logic p_clk, p_dat, p_lat, p_oen;
  int hi_len, hi_bad, viol, lat_len, lat_runs, lat2_len, oen_len, oen_max;
  logic lat_rise, lat2_rise, oen_rise, max_rise;
  int done_cnt, pd_bad;
  logic post_done, done_busy_ok;

  assign ret = (rc >= RB0 && rc < RB0 + NB) ? pat[NB - 1 - (rc - RB0)] : 1'b0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_stats();
    rc = 0; hi_len = 0; hi_bad = 0; viol = 0; lat_len = 0; lat_runs = 0;
    lat2_len = 0; lat2_rise = 1'b0; lat_rise = 1'b0; oen_len = 0; oen_max = 0;
    oen_rise = 1'b0; max_rise = 1'b0; done_cnt = 0; pd_bad = 0;
    post_done = 1'b0; done_busy_ok = 1'b1;
    p_clk = 1'b0; p_dat = 1'b0; p_lat = 1'b0; p_oen = 1'b1;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (post_done) begin
        if (busy || done) pd_bad++;
        post_done = 1'b0;
      end
      if (done) begin
        done_cnt++;
        if (!busy) done_busy_ok = 1'b0;
        post_done = 1'b1;
      end
      if (drv_clk && !p_clk) begin
        if (rc < 128) begin
          oen_r[rc] = drv_oen; lat_r[rc] = drv_latch; dat_r[rc] = drv_data;
        end
        rc++;
        if (drv_latch) lat_rise = 1'b1;
        if (!drv_oen) oen_rise = 1'b1;
      end
      if (drv_clk && (drv_data != p_dat || drv_latch != p_lat || drv_oen != p_oen)) viol++;
      if (drv_clk) hi_len++;
      else if (p_clk) begin
        if (hi_len != HALF) hi_bad++;
        hi_len = 0;
      end
      if (drv_latch) lat_len++;
      else if (p_lat) begin
        lat_runs++;
        if (lat_runs == 2) begin lat2_len = lat_len; lat2_rise = lat_rise; end
        lat_len = 0; lat_rise = 1'b0;
      end
      if (!drv_oen) oen_len++;
      else if (!p_oen) begin
        if (oen_len > oen_max) begin oen_max = oen_len; max_rise = oen_rise; end
        oen_len = 0; oen_rise = 1'b0;
      end
      p_clk = drv_clk; p_dat = drv_data; p_lat = drv_latch; p_oen = drv_oen;
    end
  end

  task automatic run_scan(input logic [NB-1:0] p, input int extra_start, input int hold);
    int guard;
    int bad;
    @(posedge clk); #1;
    pat = p;
    clear_stats();
    start = 1'b1;
    repeat (hold) @(posedge clk);
    #1 start = 1'b0;
    @(negedge clk);
    chk(busy, "R9 busy after start", longint'(busy), 1);
    guard = 0;
    while (done_cnt == 0 && guard < 6000) begin
      if (extra_start != 0 && guard == extra_start) begin
        #1 start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end else @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    chk(guard < 6000, "R9 watchdog on done", guard, 6000);
    chk(rc == NRISE, "R10 rising edge count", rc, NRISE);
    bad = 0;
    for (int k = 0; k < 5; k++)
      if (oen_r[k] != (k != 1) || lat_r[k] != (k == 3)) bad++;
    chk(bad == 0, "R2 entry key pattern", bad, 0);
    bad = 0;
    for (int k = 5; k < RB0; k++)
      if (!dat_r[k] || lat_r[k] || !oen_r[k]) bad++;
    chk(bad == 0, "R3 all-ones load", bad, 0);
    chk(lat_runs == 2 && lat2_len == 2 * HALF && !lat2_rise, "R4 latch slot",
        lat2_len, 2 * HALF);
    chk(oen_max == SENSE_CYC && !max_rise, "R5 sense window", oen_max, SENSE_CYC);
    bad = 0;
    for (int k = RB0; k < RB0 + NB; k++)
      if (!oen_r[k] || lat_r[k]) bad++;
    chk(bad == 0, "R6 readback levels", bad, 0);
    chk(faults == p, "R6 fault vector", longint'(faults), longint'(p));
    bad = 0;
    for (int k = RB0 + NB; k < NRISE; k++)
      if (oen_r[k] != ((k - RB0 - NB) != 1) || lat_r[k]) bad++;
    chk(bad == 0, "R7 exit key pattern", bad, 0);
    chk(hi_bad == 0 && viol == 0, "R8 clock phases", hi_bad + viol, 0);
    chk(done_cnt == 1 && done_busy_ok && pd_bad == 0, "R9 done pulse", done_cnt, 1);
    chk(!busy && drv_oen && !drv_clk && !drv_latch, "R1 idle after scan",
        {busy, drv_oen, drv_clk, drv_latch}, 4'b0100);
  endtask

  initial begin
    void'($urandom(32'd4711));
    clear_stats();
    repeat (3) @(negedge clk);
    chk(drv_oen && !drv_clk && !drv_latch && !drv_data && !busy && !done,
        "R1 reset outputs", {drv_oen, drv_clk, drv_latch, drv_data, busy, done}, 6'b100000);
    chk(faults == '1, "R1 reset fault vector", longint'(faults), longint'({NB{1'b1}}));
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && drv_oen, "R1 idle without start", {busy, drv_oen}, 2'b01);
    run_scan('1, 0, 1);
    run_scan('0, 0, 1);
    run_scan(~(NB'(1)), 0, 1);            // only the nearest device's channel 0 faulty
    run_scan(~(NB'(1) << (NB - 1)), 0, 1); // only the farthest device's channel 15 faulty
    run_scan({(NB/2){2'b10}}, 400, 1);     // R10: extra start mid-scan
    run_scan(NB'($urandom()), 0, 4);       // R10: start held for several cycles
    for (int i = 0; i < 3; i++) run_scan(NB'($urandom()), (i == 1) ? 1200 : 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule